// File: doc/BRIEF.md
# Watchdog Timer with Clear-and-Reload

This block is a watchdog down-counter behind a simple APB-style register slave. Software sets a reload value and enables the counter. The counter then steps down by one on every cycle where the tick input is high. When it reaches zero it raises a raw interrupt flag. On the next tick it reloads and keeps counting. Any write to the clear register drops the flag and restarts the countdown from the reload value in a single access. Well-behaved software therefore keeps the system alive by clearing the interrupt periodically.

If the countdown reaches zero a second time while the flag is still raised, and the reset enable bit is set, the block raises a reset request. That request stays high until the block itself is reset. A lock register guards the configuration against stray writes: writing a fixed key opens the other registers, and writing any other value closes them. The tick input comes from an external divider, so the count rate follows whatever rate that divider produces, including a change partway through a countdown.

Top module: `clrld_watchdog`

## Requirements
- R1: After synchronous reset, the reload value and the count both read 0xFFFFFFFF, the control field reads 0, the raw flag is 0, the block is unlocked (lock register reads 0), and both outputs are low.
- R2: Word offsets on `paddr` select the registers as follows; any other offset reads 0:
  - 0x000: reload value (read/write).
  - 0x004: current count (read only).
  - 0x008: control. Bit 0 is the count/interrupt enable and bit 1 is the reset enable; the other bits read 0.
  - 0x00C: clear (write only, reads 0).
  - 0x010: raw flag in bit 0.
  - 0x014: masked flag in bit 0.
  - 0xC00: lock state in bit 0.
- R3: A permitted write to the reload register sets the count to the written value in the cycle after the access phase.
- R4: While enabled, the count changes only on cycles where `tick_i` is 1, one step per such cycle, so a change in tick spacing changes the remaining time accordingly. With the enable at 0, the count holds.
- R5: A tick that takes the count from 1 to 0 sets the raw flag, and the count then reads 0.
- R6: A tick while the count is 0 reloads the count from the reload register; counting continues from there.
- R7: A permitted write of any data to the clear register clears the raw flag and loads the count from the reload register. It takes priority over a tick in the same cycle.
- R8: `irq_o` and the masked flag both equal the raw flag ANDed with control bit 0.
- R9: When a tick takes the count from 1 to 0 while the raw flag is already 1 and control bit 1 is 1, `rst_req_o` goes high and stays high until reset.
- R10: A write of 0x1ACCE551 to the lock register unlocks the block; a write of any other value locks it. While locked, writes to reload, control and clear have no effect. The lock register itself stays writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte offset of the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, combinational from `paddr` |
| tick_i | input | 1 | Count enable pulse from the external divider |
| irq_o | output | 1 | Timeout interrupt (masked flag) |
| rst_req_o | output | 1 | Sticky reset request after a second timeout |

## Verification
The hardest state to reach is the reset request. It needs two full countdowns with no clear in between, the reset enable set, and the tick still running. The stimulus therefore loads a short reload value, sets both control bits, and then simply lets the counter run past two zero crossings while never touching the clear register. A second hard corner is a clear or configuration write made while locked. To reach it, the bench first builds up a raised flag and a known reload value, then locks the block, and reads the state back to show the blocked writes left it unchanged. The tick spacing is varied mid-countdown so that the reference model, which steps on the same tick pattern, shows the count following the tick rather than the clock.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    parameter int unsigned BUS_W  = 32;
    parameter int unsigned ADDR_W = 12;

    localparam logic [ADDR_W-1:0] OFS_RELOAD = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_COUNT  = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 12'h008;
    localparam logic [ADDR_W-1:0] OFS_CLEAR  = 12'h00C;
    localparam logic [ADDR_W-1:0] OFS_RAW    = 12'h010;
    localparam logic [ADDR_W-1:0] OFS_MASKED = 12'h014;
    localparam logic [ADDR_W-1:0] OFS_GUARD  = 12'hC00;

    localparam logic [BUS_W-1:0] OPEN_KEY = 32'h1ACC_E551;

    typedef struct packed {
        logic rst_en;
        logic run;
    } ctrl_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_RELOAD,
        SEL_COUNT,
        SEL_CTRL,
        SEL_CLEAR,
        SEL_RAW,
        SEL_MASKED,
        SEL_GUARD
    } reg_sel_e;

    function automatic reg_sel_e decode_ofs(input logic [ADDR_W-1:0] a);
        case (a)
            OFS_RELOAD: return SEL_RELOAD;
            OFS_COUNT:  return SEL_COUNT;
            OFS_CTRL:   return SEL_CTRL;
            OFS_CLEAR:  return SEL_CLEAR;
            OFS_RAW:    return SEL_RAW;
            OFS_MASKED: return SEL_MASKED;
            OFS_GUARD:  return SEL_GUARD;
            default:    return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/wdog_regfile.sv
module wdog_regfile
    import wdog_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                psel,
    input  logic                penable,
    input  logic                pwrite,
    input  logic [ADDR_W-1:0]   paddr,
    input  logic [BUS_W-1:0]    pwdata,
    output logic [BUS_W-1:0]    prdata,
    input  logic [CNT_W-1:0]    cnt_i,
    input  logic                raw_i,
    output ctrl_t               ctrl_o,
    output logic [CNT_W-1:0]    reload_o,
    output logic                locked_o,
    output logic                reload_wr_o,
    output logic                clear_wr_o
);

    reg_sel_e         sel;
    logic             wr_acc;
    logic             wr_open;
    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] reload_q;
    logic             locked_q;

    function automatic logic [BUS_W-1:0] widen(input logic [CNT_W-1:0] v);
        logic [BUS_W-1:0] r;
        r = '0;
        r[CNT_W-1:0] = v;
        return r;
    endfunction

    assign sel     = decode_ofs(paddr);
    assign wr_acc  = psel & penable & pwrite;
    assign wr_open = wr_acc & ~locked_q;

    assign reload_wr_o = wr_open && (sel == SEL_RELOAD);
    assign clear_wr_o  = wr_open && (sel == SEL_CLEAR);

    always_ff @(posedge clk) begin
        if (rst) begin
            reload_q <= '1;
            ctrl_q   <= '0;
            locked_q <= 1'b0;
        end else begin
            if (reload_wr_o) begin
                reload_q <= pwdata[CNT_W-1:0];
            end
            if (wr_open && (sel == SEL_CTRL)) begin
                ctrl_q <= ctrl_t'(pwdata[1:0]);
            end
            if (wr_acc && (sel == SEL_GUARD)) begin
                locked_q <= (pwdata != OPEN_KEY);
            end
        end
    end

    always_comb begin
        prdata = '0;
        case (sel)
            SEL_RELOAD: prdata = widen(reload_q);
            SEL_COUNT:  prdata = widen(cnt_i);
            SEL_CTRL:   prdata[1:0] = ctrl_q;
            SEL_RAW:    prdata[0] = raw_i;
            SEL_MASKED: prdata[0] = raw_i & ctrl_q.run;
            SEL_GUARD:  prdata[0] = locked_q;
            default:    prdata = '0;
        endcase
    end

    assign ctrl_o   = ctrl_q;
    assign reload_o = reload_q;
    assign locked_o = locked_q;

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             run_i,
    input  logic             rst_en_i,
    input  logic [CNT_W-1:0] reload_i,
    input  logic             reload_wr_i,
    input  logic [CNT_W-1:0] wr_val_i,
    input  logic             clear_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             raw_o,
    output logic             rst_req_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic             raw_q;
    logic             req_q;
    logic             step;
    logic             at_zero;
    logic             expiring;

    assign step     = run_i & tick_i;
    assign at_zero  = (cnt_q == '0);
    assign expiring = (cnt_q == ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '1;
            raw_q <= 1'b0;
            req_q <= 1'b0;
        end else if (reload_wr_i) begin
            cnt_q <= wr_val_i;
        end else if (clear_i) begin
            cnt_q <= reload_i;
            raw_q <= 1'b0;
        end else if (step) begin
            if (at_zero) begin
                cnt_q <= reload_i;
            end else begin
                cnt_q <= cnt_q - ONE;
                if (expiring) begin
                    raw_q <= 1'b1;
                    if (raw_q && rst_en_i) begin
                        req_q <= 1'b1;
                    end
                end
            end
        end
    end

    assign cnt_o     = cnt_q;
    assign raw_o     = raw_q;
    assign rst_req_o = req_q;

endmodule

// File: rtl/clrld_watchdog.sv
module clrld_watchdog
    import wdog_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [BUS_W-1:0]  pwdata,
    output logic [BUS_W-1:0]  prdata,
    input  logic              tick_i,
    output logic              irq_o,
    output logic              rst_req_o
);

    ctrl_t            ctrl;
    logic [CNT_W-1:0] reload_val;
    logic [CNT_W-1:0] cnt;
    logic             raw;
    logic             locked;
    logic             reload_wr;
    logic             clear_wr;

    wdog_regfile #(.CNT_W(CNT_W)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .psel        (psel),
        .penable     (penable),
        .pwrite      (pwrite),
        .paddr       (paddr),
        .pwdata      (pwdata),
        .prdata      (prdata),
        .cnt_i       (cnt),
        .raw_i       (raw),
        .ctrl_o      (ctrl),
        .reload_o    (reload_val),
        .locked_o    (locked),
        .reload_wr_o (reload_wr),
        .clear_wr_o  (clear_wr)
    );

    wdog_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk         (clk),
        .rst         (rst),
        .tick_i      (tick_i),
        .run_i       (ctrl.run),
        .rst_en_i    (ctrl.rst_en),
        .reload_i    (reload_val),
        .reload_wr_i (reload_wr),
        .wr_val_i    (pwdata[CNT_W-1:0]),
        .clear_i     (clear_wr),
        .cnt_o       (cnt),
        .raw_o       (raw),
        .rst_req_o   (rst_req_o)
    );

    assign irq_o = raw & ctrl.run;

endmodule

// File: rtl/clrld_watchdog_checker.sv
module clrld_watchdog_checker
    import wdog_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic [BUS_W-1:0]  pwdata,
    input logic              tick_i,
    input logic              irq_o,
    input logic              rst_req_o,
    input logic [CNT_W-1:0]  cnt,
    input logic              raw,
    input logic [CNT_W-1:0]  reload_val,
    input logic              locked
);

    logic wr_any;
    assign wr_any = psel & penable & pwrite;

    p_reload_sets_count_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_any && !locked && paddr == OFS_RELOAD) |=> (cnt == $past(pwdata[CNT_W-1:0])));

    p_hold_without_tick_r4: assert property (@(posedge clk) disable iff (rst)
        (!tick_i && !wr_any) |=> $stable(cnt));

    p_flag_at_zero_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(raw) |-> (cnt == '0));

    p_clear_restarts_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_any && !locked && paddr == OFS_CLEAR) |=> (!raw && cnt == $past(reload_val)));

    p_irq_needs_flag_r8: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> raw);

    p_request_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        rst_req_o |=> rst_req_o);

    p_locked_reload_kept_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_any && locked && paddr != OFS_GUARD) |=> $stable(reload_val));

endmodule

bind clrld_watchdog clrld_watchdog_checker #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .psel       (psel),
    .penable    (penable),
    .pwrite     (pwrite),
    .paddr      (paddr),
    .pwdata     (pwdata),
    .tick_i     (tick_i),
    .irq_o      (irq_o),
    .rst_req_o  (rst_req_o),
    .cnt        (cnt),
    .raw        (raw),
    .reload_val (reload_val),
    .locked     (locked)
);

// File: tb/clrld_watchdog_test.sv
module clrld_watchdog_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        psel, penable, pwrite, tick;
    logic [11:0] paddr;
    logic [31:0] pwdata;
    logic [31:0] prdata;
    logic        irq, rreq;

    always #2 clk = ~clk;

    clrld_watchdog uut (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .tick_i(tick),
        .irq_o(irq), .rst_req_o(rreq)
    );

    int    vectors = 0;
    int    fails   = 0;
    int    div     = 1;
    int    tcnt    = 0;
    bit    live    = 0;
    string cur_tag = "R2";

    // behavioural reference state
    logic [31:0] m_load, m_cnt;
    logic        m_run, m_ren, m_ris, m_rr, m_lock;

    always @(posedge clk) begin : ref_model
        bit took, old_run, old_ren;
        if (rst) begin
            m_load = 32'hFFFF_FFFF; m_cnt = 32'hFFFF_FFFF;
            m_run = 0; m_ren = 0; m_ris = 0; m_rr = 0; m_lock = 0;
        end else begin
            took = 0; old_run = m_run; old_ren = m_ren;
            if (psel && penable && pwrite) begin
                if (paddr == 12'hC00) m_lock = (pwdata != 32'h1ACCE551);
                else if (!m_lock) begin
                    if (paddr == 12'h000) begin m_load = pwdata; m_cnt = pwdata; took = 1; end
                    if (paddr == 12'h008) begin m_run = pwdata[0]; m_ren = pwdata[1]; end
                    if (paddr == 12'h00C) begin m_ris = 0; m_cnt = m_load; took = 1; end
                end
            end
            if (!took && old_run && tick) begin
                if (m_cnt == 0) m_cnt = m_load;
                else begin
                    if (m_cnt == 1) begin
                        if (m_ris && old_ren) m_rr = 1;
                        m_ris = 1;
                    end
                    m_cnt = m_cnt - 1;
                end
            end
        end
    end

    function automatic logic [31:0] m_read(input logic [11:0] a);
        case (a)
            12'h000: return m_load;
            12'h004: return m_cnt;
            12'h008: return {30'b0, m_ren, m_run};
            12'h010: return {31'b0, m_ris};
            12'h014: return {31'b0, m_ris & m_run};
            12'hC00: return {31'b0, m_lock};
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        if (live && !rst) begin
            chk({31'b0, irq},  {31'b0, m_ris & m_run}, "R8");
            chk({31'b0, rreq}, {31'b0, m_rr},          "R9");
            if (psel) chk(prdata, m_read(paddr), cur_tag);
        end
        tcnt++;
        tick = (tcnt % div == 0);
    endtask

    task automatic run(input int n);
        repeat (n) cyc();
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
        cyc();
        penable = 1;
        cyc();
        psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic rd_exp(input logic [11:0] a, input logic [31:0] exp, input string tag);
        psel = 1; pwrite = 0; penable = 0; paddr = a;
        cyc();
        penable = 1;
        #1 chk(prdata, exp, tag);
        cyc();
        psel = 0; penable = 0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL run: watchdog expired, actual hung expected done");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin : stim
        rst = 1; psel = 0; penable = 0; pwrite = 0; paddr = '0; pwdata = '0; tick = 0;
        repeat (3) @(negedge clk);
        rst = 0; live = 1;

        // R1 reset state
        chk({31'b0, irq},  0, "R1");
        chk({31'b0, rreq}, 0, "R1");
        rd_exp(12'h000, 32'hFFFF_FFFF, "R1");
        rd_exp(12'h004, 32'hFFFF_FFFF, "R1");
        rd_exp(12'h008, 0, "R1");
        rd_exp(12'h010, 0, "R1");
        rd_exp(12'hC00, 0, "R1");

        // R2 unmapped and write-only offsets
        rd_exp(12'h018, 0, "R2");
        rd_exp(12'h00C, 0, "R2");

        // R3 reload write sets count
        cur_tag = "R3";
        wr(12'h000, 32'd20);
        rd_exp(12'h004, 32'd20, "R3");
        rd_exp(12'h000, 32'd20, "R2");

        // R5 / R6 timeout and reload, tick every cycle
        cur_tag = "R5";
        wr(12'h008, 32'h1);
        run(22);
        rd_exp(12'h010, 1, "R5");
        rd_exp(12'h014, 1, "R8");
        cur_tag = "R6";
        run(30);

        // R7 clear restarts count
        cur_tag = "R7";
        wr(12'h00C, 32'hDEAD_BEEF);
        chk({31'b0, irq}, 0, "R7");
        rd_exp(12'h010, 0, "R7");

        // R4 tick rate changes mid countdown, then hold while disabled
        cur_tag = "R4";
        wr(12'h008, 0);
        wr(12'h000, 32'd100);
        div = 4;
        wr(12'h008, 32'h1);
        run(60);
        div = 1;
        run(30);
        wr(12'h008, 0);
        rd_exp(12'h004, m_cnt, "R4");
        run(10);
        rd_exp(12'h004, m_cnt, "R4");

        // R8 masked view drops with enable
        cur_tag = "R8";
        wr(12'h00C, 0);
        wr(12'h000, 32'd2);
        wr(12'h008, 32'h1);
        run(6);
        wr(12'h008, 0);
        rd_exp(12'h010, 1, "R8");
        rd_exp(12'h014, 0, "R8");
        chk({31'b0, irq}, 0, "R8");

        // R9 second timeout raises sticky reset request
        cur_tag = "R9";
        wr(12'h00C, 0);
        wr(12'h000, 32'd5);
        wr(12'h008, 32'h3);
        run(20);
        chk({31'b0, rreq}, 1, "R9");
        wr(12'h00C, 0);
        run(3);
        chk({31'b0, rreq}, 1, "R9");
        rst = 1;
        cyc(); cyc();
        rst = 0;
        cyc();
        chk({31'b0, rreq}, 0, "R9");

        // R10 lock blocks writes
        cur_tag = "R10";
        wr(12'h000, 32'd3);
        wr(12'h008, 32'h1);
        run(6);
        wr(12'h008, 0);
        wr(12'hC00, 32'h0);
        rd_exp(12'hC00, 1, "R10");
        wr(12'h00C, 0);
        rd_exp(12'h010, 1, "R10");
        wr(12'h000, 32'd7);
        rd_exp(12'h000, 32'd3, "R10");
        wr(12'h008, 32'h3);
        rd_exp(12'h008, 0, "R10");
        wr(12'hC00, 32'h1ACC_E551);
        rd_exp(12'hC00, 0, "R10");
        wr(12'h000, 32'd7);
        rd_exp(12'h000, 32'd7, "R10");
        wr(12'hC00, 32'h1ACC_E550);
        rd_exp(12'hC00, 1, "R10");

        run(4);
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule